// File: doc/BRIEF.md
# Maskable Interrupt Factor Controller

This block collects interrupt events from three kinds of source and turns them into one interrupt request for a small CPU core. The sources are groups of input pins, where a change in either direction on any pin of a group is an event; four clock-timer taps, where a high-to-low transition is an event; and a single pulse that marks the end of a dialing cycle (a digit, a pause or a flash). Each source owns a factor flag and an enable bit in a shared mask word.

Software sees the block through a small register port. A read of a source's flag address returns the flag and clears it on that access. The mask word is written and read at the top address. A global enable bit is set and cleared by the core's enable and disable instructions. Accepting a request clears it again, so nested interrupts are blocked until software re-enables them. While the global enable is set, the mask word cannot be changed. The block also presents the index of the most urgent pending enabled source as a vector.

Top module: `irq_factor_ctrl`

## Requirements
- R1: After reset all factor flags, the mask word and the global enable are 0, so `irq_req` is 0, `irq_vec` is 0 and a read of the mask address returns 0.
- R2: A high-to-low change on timer tap t (bit 0 = 32 Hz, bit 1 = 16 Hz, bit 2 = 2 Hz, bit 3 = 1 Hz) sets the flag of source N_GRP+t, whatever its mask bit holds.
- R3: From the second clock after reset onwards, a change in either direction of any pin in group g (pins g*GRP_W up to g*GRP_W+GRP_W-1) sets the flag of source g, whatever its mask bit holds.
- R4: A cycle with `dial_done` high sets the flag of source N_GRP+4, the last and lowest-priority source.
- R5: A read of address k (k below the number of sources) returns the flag of source k in data bit 0, with all other bits 0, and clears that flag. A read of an unused address returns 0.
- R6: An event that arrives in the same cycle as a read of its own flag leaves the flag set.
- R7: `irq_req` is 1 exactly when the global enable is 1 and at least one source has both its flag and its mask bit set.
- R8: `irq_ack` clears the global enable and takes priority over `ei_set`. `di_set` clears it, `ei_set` sets it, and the state appears on `gie`.
- R9: A write to the mask address (all ones) loads data bits 0 up to the number of sources minus 1 into the mask word only while the global enable is 0. While it is 1, the write is ignored. The mask reads back at that address.
- R10: `irq_vec` holds the lowest source index whose flag and mask bit are both set, or 0 if there is none.
- R11: Writes to flag addresses change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | N_GRP*GRP_W | Input pin groups, watched for changes in either direction |
| timer_taps | input | N_TAP | Clock-timer taps, watched for falling edges |
| dial_done | input | 1 | One-cycle pulse when a dialing cycle ends |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rd | input | 1 | Read strobe; clears the flag that is read |
| reg_rdata | output | DW | Read data, combinational from the address |
| ei_set | input | 1 | Set global enable |
| di_set | input | 1 | Clear global enable |
| irq_ack | input | 1 | Core accepts the request; clears global enable |
| gie | output | 1 | Global enable state |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the pending enabled source with the lowest index |

## Verification
The assertions assume that `reg_addr` is stable while a strobe is high within a cycle. They also assume that the event inputs are already synchronous to `clk`, so that each pin and tap value seen at an edge is the one that is compared one cycle later. The stimulus drives every input only at the falling clock edge and changes pins and taps by single random bit flips. This produces isolated edges as well as several sources going pending together. Reads, mask writes, enables, disables and acknowledges are drawn at random rates, so reads and events often meet in the same cycle and mask writes arrive both while the global enable is set and while it is clear.

// File: rtl/irq_factor_ctrl.sv
module irq_factor_ctrl #(
  parameter int N_GRP = 4,
  parameter int GRP_W = 4,
  parameter int N_TAP = 4,
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int VEC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_GRP*GRP_W-1:0] port_pins,
  input  logic [N_TAP-1:0]       timer_taps,
  input  logic                   dial_done,
  input  logic [AW-1:0]          reg_addr,
  input  logic                   reg_wr,
  input  logic [DW-1:0]          reg_wdata,
  input  logic                   reg_rd,
  output logic [DW-1:0]          reg_rdata,
  input  logic                   ei_set,
  input  logic                   di_set,
  input  logic                   irq_ack,
  output logic                   gie,
  output logic                   irq_req,
  output logic [VEC_W-1:0]       irq_vec
);
  localparam int N_SRC = N_GRP + N_TAP + 1;
  localparam logic [AW-1:0] MASK_ADDR = '1;

  logic [N_GRP*GRP_W-1:0] pin_q;
  logic                   primed;
  logic [N_TAP-1:0]       tap_q;
  logic [N_SRC-1:0]       flag_q, mask_q, evt, rd_clr, pend;
  logic                   gie_q;
  logic                   unused_wdata;

  assign unused_wdata = ^reg_wdata;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign evt[g] = primed & |(port_pins[g*GRP_W +: GRP_W] ^ pin_q[g*GRP_W +: GRP_W]);
  end
  assign evt[N_GRP +: N_TAP] = tap_q & ~timer_taps;
  assign evt[N_SRC-1]        = dial_done;

  for (genvar k = 0; k < N_SRC; k++) begin : g_clr
    assign rd_clr[k] = reg_rd && (reg_addr == AW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      primed <= 1'b0;
      tap_q  <= '0;
      flag_q <= '0;
    end else begin
      pin_q  <= port_pins;
      primed <= 1'b1;
      tap_q  <= timer_taps;
      flag_q <= (flag_q & ~rd_clr) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (reg_wr && reg_addr == MASK_ADDR && !gie_q)
      mask_q <= reg_wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gie_q <= 1'b0;
    else if (irq_ack || di_set) gie_q <= 1'b0;
    else if (ei_set)           gie_q <= 1'b1;
  end

  assign pend    = flag_q & mask_q;
  assign irq_req = gie_q & |pend;
  assign gie     = gie_q;

  always_comb begin
    irq_vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) irq_vec = VEC_W'(i);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == MASK_ADDR)
      reg_rdata[N_SRC-1:0] = mask_q;
    else if (reg_addr < AW'(N_SRC))
      reg_rdata[0] = flag_q[reg_addr];
  end

  p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie_q);
  p_ack_drops_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie_q);
  p_mask_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gie_q |=> $stable(mask_q));
  p_vec_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend[irq_vec]);

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    p_event_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> flag_q[k]);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[k] && !evt[k]) |=> !flag_q[k]);
  end
endmodule

// File: tb/irq_factor_ctrl_tb.sv
`timescale 1ns/1ps
module irq_factor_ctrl_tb;
  localparam int NG = 4, GW = 4, NT = 4, DW = 16, AW = 4, VW = 4;
  localparam int NS = NG + NT + 1;
  localparam logic [AW-1:0] MADDR = '1;

  logic clk = 0, rst_n = 0;
  logic [NG*GW-1:0] port_pins = '0;
  logic [NT-1:0] timer_taps = '0;
  logic dial_done = 0, reg_wr = 0, reg_rd = 0, ei_set = 0, di_set = 0, irq_ack = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic gie, irq_req;
  logic [VW-1:0] irq_vec;

  always #2.5 clk = ~clk;

  irq_factor_ctrl #(.N_GRP(NG), .GRP_W(GW), .N_TAP(NT), .DW(DW), .AW(AW), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .timer_taps(timer_taps),
    .dial_done(dial_done), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .ei_set(ei_set), .di_set(di_set),
    .irq_ack(irq_ack), .gie(gie), .irq_req(irq_req), .irq_vec(irq_vec));

  int checks = 0, errs = 0;
  bit done = 0;

  logic s_rd, s_wr, s_ei, s_di, s_ack, s_dial;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [NG*GW-1:0] s_pins;
  logic [NT-1:0] s_taps;
  logic [DW-1:0] last_rdata;

  logic [NS-1:0] m_flag, m_mask;
  logic m_gie, m_primed;
  logic [NG*GW-1:0] m_pins;
  logic [NT-1:0] m_taps;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_rdata(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == MADDR) r[NS-1:0] = m_mask;
    else if (a < AW'(NS)) r[0] = m_flag[a];
    return r;
  endfunction

  function automatic logic [VW-1:0] exp_vec(logic [NS-1:0] p);
    for (int i = 0; i < NS; i++) if (p[i]) return VW'(i);
    return '0;
  endfunction

  task automatic idle();
    s_rd = 0; s_wr = 0; s_ei = 0; s_di = 0; s_ack = 0; s_dial = 0;
    s_addr = '0; s_wdata = '0;
  endtask

  task automatic cyc();
    logic [NS-1:0] ev, clr;
    @(negedge clk);
    reg_rd = s_rd; reg_wr = s_wr; reg_addr = s_addr; reg_wdata = s_wdata;
    ei_set = s_ei; di_set = s_di; irq_ack = s_ack; dial_done = s_dial;
    port_pins = s_pins; timer_taps = s_taps;
    #1;
    last_rdata = reg_rdata;
    if (s_rd) chk("R5", reg_rdata, exp_rdata(s_addr));
    chk("R7", irq_req, m_gie & |(m_flag & m_mask));
    chk("R10", irq_vec, exp_vec(m_flag & m_mask));
    chk("R8", gie, m_gie);
    for (int g = 0; g < NG; g++)
      ev[g] = m_primed & |(s_pins[g*GW +: GW] ^ m_pins[g*GW +: GW]);
    ev[NG +: NT] = m_taps & ~s_taps;
    ev[NS-1] = s_dial;
    clr = '0;
    if (s_rd && s_addr < AW'(NS)) clr[s_addr] = 1'b1;
    if (s_wr && s_addr == MADDR && !m_gie) m_mask = s_wdata[NS-1:0];
    m_flag = (m_flag & ~clr) | ev;
    if (s_ack || s_di) m_gie = 0; else if (s_ei) m_gie = 1;
    m_pins = s_pins; m_taps = s_taps; m_primed = 1;
  endtask

  task automatic rd(int a);
    idle(); s_rd = 1; s_addr = AW'(a); cyc(); idle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd1357);
    idle(); s_pins = '0; s_taps = '0;
    m_flag = '0; m_mask = '0; m_gie = 0; m_primed = 0; m_pins = '0; m_taps = '0;
    repeat (3) @(negedge clk);
    reg_addr = MADDR; #1;
    chk("R1", reg_rdata, 0); chk("R1", irq_req, 0); chk("R1", gie, 0); chk("R1", irq_vec, 0);
    @(negedge clk); rst_n = 1;

    // R11: writes to flag addresses
    idle(); s_wr = 1; s_addr = 4'd8; s_wdata = '1; cyc();
    idle(); s_wr = 1; s_addr = 4'd3; s_wdata = '1; cyc();
    rd(8); chk("R11", last_rdata, 0);
    rd(3); chk("R11", last_rdata, 0);

    // R4: dial pulse, masked
    idle(); s_dial = 1; cyc(); idle();
    rd(8); chk("R4", last_rdata, 1);
    rd(8); chk("R5", last_rdata, 0);

    // R2: tap falling edges
    s_taps = 4'hF; cyc(); s_taps = 4'h0; cyc();
    rd(4); chk("R2", last_rdata, 1);
    rd(7); chk("R2", last_rdata, 1);
    rd(5); rd(6);

    // R3: both pin edges
    s_pins[5] = 1; cyc(); rd(1); chk("R3", last_rdata, 1);
    s_pins[5] = 0; cyc(); rd(1); chk("R3", last_rdata, 1);
    rd(0); chk("R3", last_rdata, 0);

    // R6: event during read of same flag
    idle(); s_rd = 1; s_addr = 4'd8; s_dial = 1; cyc(); idle();
    rd(8); chk("R6", last_rdata, 1);

    // R9: mask lock
    idle(); s_wr = 1; s_addr = MADDR; s_wdata = '1; cyc(); idle();
    rd(15); chk("R9", last_rdata, 16'h01FF);
    s_ei = 1; cyc(); idle();
    s_wr = 1; s_addr = MADDR; s_wdata = '0; cyc(); idle();
    rd(15); chk("R9", last_rdata, 16'h01FF);

    // R10: priority among several pending
    s_dial = 1; s_pins[9] = 1; s_taps[3] = 1; cyc(); idle();
    s_taps[3] = 0; cyc();
    cyc(); chk("R10", irq_vec, 2); chk("R7", irq_req, 1);
    rd(2); cyc(); chk("R10", irq_vec, 7);
    rd(7); cyc(); chk("R10", irq_vec, 8);

    // R8: ack beats ei
    s_ack = 1; s_ei = 1; cyc(); idle();
    cyc(); chk("R8", gie, 0); chk("R7", irq_req, 0);
    s_ei = 1; cyc(); idle(); cyc(); chk("R8", gie, 1);
    s_di = 1; cyc(); idle(); cyc(); chk("R8", gie, 0);

    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 8 == 0) s_pins[$urandom % (NG*GW)] ^= 1'b1;
      if ($urandom % 4 == 0) s_taps[$urandom % NT] ^= 1'b1;
      s_dial = ($urandom % 16 == 0);
      if ($urandom % 3 == 0) begin s_rd = 1; s_addr = AW'($urandom % 16); end
      if ($urandom % 6 == 0) begin
        s_wr = 1; s_wdata = DW'($urandom);
        if (!s_rd) s_addr = ($urandom % 2 == 0) ? MADDR : AW'($urandom % 16);
      end
      s_ei = ($urandom % 10 == 0);
      s_di = ($urandom % 30 == 0);
      s_ack = (m_gie && |(m_flag & m_mask)) ? ($urandom % 4 == 0) : ($urandom % 40 == 0);
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule